// File: doc/BRIEF.md
# Sized Integer ALU with Arithmetic Status Word

This block is the integer execution slice of a simple processor core. It takes two 32-bit operands, an operation code and an operand-size select for 8, 16 or 32 bits. In the same cycle it returns a result and a write-enable for the destination. It also keeps a 16-bit status word that is updated on the clock edge at which an operation is presented. The carry held in that word feeds the carry-consuming operations: add with carry, subtract with borrow, and the two rotates through carry. Wider arithmetic and shifts are therefore built as a sequence of 32-bit steps.

The block covers add, subtract, both carry-chained forms, increment, decrement, negate, compare, AND, OR, XOR, NOT, test, a plain data move, and single-bit shifts and rotates in both directions. Every operation works only on the low 8, 16 or 32 bits chosen by the size select. Result bits above the selected size are driven to zero. Flags are taken at the top bit of the selected size.

Top module: `alu_flags_top`

## Requirements
- R1: Encodings. `op_code` values: 0 move, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 compare, 6 increment, 7 decrement, 8 negate, 9 AND, 10 OR, 11 XOR, 12 NOT, 13 test, 14 rotate left, 15 rotate right, 16 rotate left through carry, 17 rotate right through carry, 18 shift left, 19 logical shift right, 20 arithmetic shift right. `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Codes 21 to 31 give result 0, no write and no flag change. `result` is combinational and is zero above the selected size. `flags` changes only at a rising edge with `op_valid` high. Otherwise it holds.
- R2: Flag layout. Carry is bit 0, parity bit 2, half carry bit 4, zero bit 6, sign bit 7 and overflow bit 11. Every other bit of `flags` is always 0, and all 16 bits are 0 after a synchronous reset.
- R3: Add and add-with-carry (which adds the held carry as well) set carry to the carry out of the top bit of the selected size. Half carry is set to the carry from bit 3 into bit 4. Overflow is set when both operands share a sign and the result's sign differs from it.
- R4: Subtract, subtract-with-borrow (which also takes away the held carry), compare and negate (0 minus A) set carry when a borrow occurs. Overflow is set when the operands differ in sign and the result's sign differs from the minuend's. Half carry is set to the borrow into bit 4. For negate, carry equals "A is not zero".
- R5: Every flag-updating operation except the rotates sets zero when the sized result is 0, sign from its top bit, and parity when the low 8 result bits hold an even count of ones.
- R6: Increment and decrement update every arithmetic flag except carry, which keeps its value.
- R7: Compare and test hold `res_wr` low. Their flags match subtract and AND on the same inputs.
- R8: AND, OR, XOR and test clear carry, overflow and half carry. NOT returns the inverted A and leaves all flags unchanged.
- R9: Move returns the sized B operand with `res_wr` high and leaves all flags unchanged.
- R10: The rotates change only carry and overflow. Carry receives the bit moved out. Overflow becomes the XOR of the two top result bits for right rotates, and the XOR of the result's top bit with the new carry for left rotates. The through-carry forms shift the old carry into the vacated bit.
- R11: Shift left fills with 0, and logical shift right fills the top bit with 0. Arithmetic shift right repeats the sign bit. Carry receives the bit shifted out and half carry is cleared. Overflow is as for a left rotate on shift left, the original top bit on logical right, and 0 on arithmetic right.
- R12: A 64-bit add done as a low add then a high add-with-carry, and a 64-bit right shift done as a logical right shift of the high word then a rotate right through carry of the low word, give the correct words. This holds even when a move sits between the two steps.
- R13: `res_wr` is high only with `op_valid` high and an operation that writes a result: move, the arithmetic ops other than compare, the logic ops other than test, and all shifts and rotates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select (R1) |
| op_size | input | 2 | Operand size select (R1) |
| opnd_a | input | 32 | First operand, destination side |
| opnd_b | input | 32 | Second operand, source side |
| result | output | 32 | Sized result, combinational |
| res_wr | output | 1 | Destination write enable, combinational |
| flags | output | 16 | Registered status word (R2) |

## Verification
`result` and `res_wr` are combinational, so the bench reads them in the same low clock phase in which it drives the inputs. At that point they reflect the status word as it stood before the operation. The new status word is due one edge later. The bench reads it a short time after the rising edge, then carries its model's flag state forward to the next operation. Idle cycles are checked in the same way, so any flag change without `op_valid` is caught at the edge where it happens.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes, size codes and flag positions of the ALU.
// Assumes: flag bit positions are fixed by software-visible behaviour.
package alu_pkg;

    typedef enum logic [4:0] {
        OP_MOV  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBB  = 5'd4,
        OP_CMP  = 5'd5,
        OP_INC  = 5'd6,
        OP_DEC  = 5'd7,
        OP_NEG  = 5'd8,
        OP_AND  = 5'd9,
        OP_OR   = 5'd10,
        OP_XOR  = 5'd11,
        OP_NOT  = 5'd12,
        OP_TEST = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_RCL  = 5'd16,
        OP_RCR  = 5'd17,
        OP_SHL  = 5'd18,
        OP_SHR  = 5'd19,
        OP_SAR  = 5'd20
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } alu_size_e;

    localparam int FLAG_W  = 16;
    localparam int CF_POS  = 0;
    localparam int PF_POS  = 2;
    localparam int AF_POS  = 4;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int OF_POS  = 11;

    // One bit per arithmetic flag; used both as values and as update masks.
    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flag_set_t;

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
// Module: sized adder/subtractor.
// Computes x + y + cin or x - y - cin on operands already masked to the
// selected size; reports carry/borrow out of the sized top bit, the carry
// or borrow into bit 4, and signed overflow. Assumes DATA_W >= 16.
module alu_arith #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [IDX_W-1:0]  msb_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              aux_o,
    output logic              ovf_o
);

    logic [DATA_W:0]   raw;
    logic [IDX_W:0]    cidx;
    logic              sx, sy, sr;
    logic [DATA_W-1:0] mix;

    // Wide add or subtract; borrow appears as the bit above the sized msb.
    always_comb begin
        if (sub_i) raw = {1'b0, x_i} - {1'b0, y_i} - {{DATA_W{1'b0}}, cin_i};
        else       raw = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
    end

    assign cidx  = {1'b0, msb_i} + {{IDX_W{1'b0}}, 1'b1};
    assign res_o = raw[DATA_W-1:0] & mask_i;

    // Carry-out, half carry and signed overflow from the sized view.
    always_comb begin
        carry_o = raw[cidx];
        mix     = x_i ^ y_i ^ raw[DATA_W-1:0];
        aux_o   = mix[4];
        sx      = x_i[msb_i];
        sy      = y_i[msb_i];
        sr      = res_o[msb_i];
        if (sub_i) ovf_o = (sx != sy) && (sr != sx);
        else       ovf_o = (sx == sy) && (sr != sx);
    end

endmodule

// File: rtl/alu_bitops.sv
`timescale 1ns/1ps
// Module: bitwise logic and single-bit shift/rotate unit.
// Operands arrive masked to the selected size; msb_i names the sized top
// bit. Produces the result plus the carry and overflow the op defines.
// Assumes msb_i >= 7 so the bit below the top always exists.
module alu_bitops
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cf_i,
    input  logic [IDX_W-1:0]  msb_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o,
    output logic              of_o
);

    logic              top, nxt, low;
    logic [DATA_W-1:0] top_hot;
    logic [DATA_W-1:0] shl1, shr1;

    // Shared views of the sized operand.
    always_comb begin
        top     = a_i[msb_i];
        nxt     = a_i[msb_i - IDX_W'(1)];
        low     = a_i[0];
        top_hot = {{(DATA_W-1){1'b0}}, 1'b1} << msb_i;
        shl1    = (a_i << 1) & mask_i;
        shr1    = a_i >> 1;
    end

    // Per-operation result, carry and overflow.
    always_comb begin
        res_o = '0;
        cf_o  = 1'b0;
        of_o  = 1'b0;
        case (op_i)
            OP_AND, OP_TEST: res_o = a_i & b_i;
            OP_OR:           res_o = a_i | b_i;
            OP_XOR:          res_o = a_i ^ b_i;
            OP_NOT:          res_o = ~a_i & mask_i;
            OP_ROL: begin
                res_o = shl1 | {{(DATA_W-1){1'b0}}, top};
                cf_o  = top;
                of_o  = nxt ^ top;
            end
            OP_RCL: begin
                res_o = shl1 | {{(DATA_W-1){1'b0}}, cf_i};
                cf_o  = top;
                of_o  = nxt ^ top;
            end
            OP_SHL: begin
                res_o = shl1;
                cf_o  = top;
                of_o  = nxt ^ top;
            end
            OP_ROR: begin
                res_o = shr1 | (low ? top_hot : '0);
                cf_o  = low;
                of_o  = low ^ top;
            end
            OP_RCR: begin
                res_o = shr1 | (cf_i ? top_hot : '0);
                cf_o  = low;
                of_o  = cf_i ^ top;
            end
            OP_SHR: begin
                res_o = shr1;
                cf_o  = low;
                of_o  = top;
            end
            OP_SAR: begin
                res_o = shr1 | (top ? top_hot : '0);
                cf_o  = low;
                of_o  = 1'b0;
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_status.sv
`timescale 1ns/1ps
// Module: status word register.
// Derives zero, sign and parity from the sized result, merges them with the
// carry/half-carry/overflow supplied by the datapath, and loads only the
// flags named in upd_i when load_i is high. Unused bits stay zero.
module alu_status
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  flag_set_t         upd_i,
    input  logic              cf_i,
    input  logic              af_i,
    input  logic              of_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [IDX_W-1:0]  msb_i,
    output logic [FLAG_W-1:0] flags_o
);

    flag_set_t nxt;
    flag_set_t cur;

    // New flag values from the datapath and the result.
    always_comb begin
        nxt.cf = cf_i;
        nxt.af = af_i;
        nxt.of = of_i;
        nxt.zf = (res_i == '0);
        nxt.sf = res_i[msb_i];
        nxt.pf = ~^res_i[7:0];
    end

    // Flag storage with per-flag load enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load_i) begin
            if (upd_i.cf) cur.cf <= nxt.cf;
            if (upd_i.pf) cur.pf <= nxt.pf;
            if (upd_i.af) cur.af <= nxt.af;
            if (upd_i.zf) cur.zf <= nxt.zf;
            if (upd_i.sf) cur.sf <= nxt.sf;
            if (upd_i.of) cur.of <= nxt.of;
        end
    end

    // Place stored flags at their fixed positions.
    always_comb begin
        flags_o         = '0;
        flags_o[CF_POS] = cur.cf;
        flags_o[PF_POS] = cur.pf;
        flags_o[AF_POS] = cur.af;
        flags_o[ZF_POS] = cur.zf;
        flags_o[SF_POS] = cur.sf;
        flags_o[OF_POS] = cur.of;
    end

endmodule

// File: rtl/alu_flags_top.sv
`timescale 1ns/1ps
// Module: sized ALU with registered status word (top).
// Result and write enable are combinational from the inputs and the current
// flags; the status word is loaded on the clock edge with op_valid high.
// Assumes DATA_W >= 16; sizes are 8, 16 and DATA_W bits.
module alu_flags_top
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              res_wr,
    output logic [FLAG_W-1:0] flags
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-8){1'b0}}, 8'hFF};
    localparam logic [DATA_W-1:0] MASK_H = {{(DATA_W-16){1'b0}}, 16'hFFFF};
    localparam logic [DATA_W-1:0] ONE    = {{(DATA_W-1){1'b0}}, 1'b1};

    alu_op_e           op_e;
    logic [IDX_W-1:0]  msb_idx;
    logic [DATA_W-1:0] mask, a_m, b_m;
    logic              cf_cur;

    logic [DATA_W-1:0] ar_x, ar_y, ar_res;
    logic              ar_sub, ar_cin, ar_c, ar_af, ar_of;
    logic [DATA_W-1:0] bo_res;
    logic              bo_cf, bo_of;

    logic              sel_cf, sel_af, sel_of;
    flag_set_t         upd;
    logic              writes;

    assign op_e   = alu_op_e'(op_code);
    assign cf_cur = flags[CF_POS];

    // Size decode: top bit index and operand mask.
    always_comb begin
        case (alu_size_e'(op_size))
            SZ_BYTE: begin msb_idx = IDX_W'(7);  mask = MASK_B; end
            SZ_HALF: begin msb_idx = IDX_W'(15); mask = MASK_H; end
            default: begin msb_idx = IDX_W'(DATA_W-1); mask = '1; end
        endcase
        a_m = opnd_a & mask;
        b_m = opnd_b & mask;
    end

    // Operand steering for the adder/subtractor.
    always_comb begin
        ar_x   = a_m;
        ar_y   = b_m;
        ar_sub = 1'b0;
        ar_cin = 1'b0;
        case (op_e)
            OP_ADC:         ar_cin = cf_cur;
            OP_SUB, OP_CMP: ar_sub = 1'b1;
            OP_SBB: begin ar_sub = 1'b1; ar_cin = cf_cur; end
            OP_INC:         ar_y = ONE;
            OP_DEC: begin ar_sub = 1'b1; ar_y = ONE; end
            OP_NEG: begin ar_sub = 1'b1; ar_x = '0; ar_y = a_m; end
            default: ;
        endcase
    end

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .x_i    (ar_x),
        .y_i    (ar_y),
        .cin_i  (ar_cin),
        .sub_i  (ar_sub),
        .msb_i  (msb_idx),
        .mask_i (mask),
        .res_o  (ar_res),
        .carry_o(ar_c),
        .aux_o  (ar_af),
        .ovf_o  (ar_of)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bits (
        .op_i  (op_e),
        .a_i   (a_m),
        .b_i   (b_m),
        .cf_i  (cf_cur),
        .msb_i (msb_idx),
        .mask_i(mask),
        .res_o (bo_res),
        .cf_o  (bo_cf),
        .of_o  (bo_of)
    );

    // Result source, write intent and flag-update set per operation.
    always_comb begin
        result = '0;
        writes = 1'b1;
        upd    = '0;
        sel_cf = bo_cf;
        sel_af = 1'b0;
        sel_of = bo_of;
        case (op_e)
            OP_MOV: result = b_m;
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
                result = ar_res;
                writes = (op_e != OP_CMP);
                upd    = '1;
                sel_cf = ar_c;
                sel_af = ar_af;
                sel_of = ar_of;
            end
            OP_INC, OP_DEC: begin
                result = ar_res;
                upd    = '{cf: 1'b0, default: 1'b1};
                sel_cf = ar_c;
                sel_af = ar_af;
                sel_of = ar_of;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                result = bo_res;
                writes = (op_e != OP_TEST);
                upd    = '1;
            end
            OP_NOT: result = bo_res;
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                result = bo_res;
                upd    = '{cf: 1'b1, of: 1'b1, default: 1'b0};
            end
            OP_SHL, OP_SHR, OP_SAR: begin
                result = bo_res;
                upd    = '1;
            end
            default: writes = 1'b0;
        endcase
    end

    assign res_wr = op_valid & writes;

    alu_status #(.DATA_W(DATA_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (op_valid),
        .upd_i  (upd),
        .cf_i   (sel_cf),
        .af_i   (sel_af),
        .of_i   (sel_of),
        .res_i  (result),
        .msb_i  (msb_idx),
        .flags_o(flags)
    );

endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
// Module: property checker for alu_flags_top, bound to every instance.
// Observes ports only; relates result, write enable and status word.
module alu_flags_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] result,
    input logic              res_wr,
    input logic [FLAG_W-1:0] flags
);

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & 16'hF72A) == 16'h0000);

    // R1
    idle_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags));

    // R9
    move_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MOV) |=> $stable(flags));

    // R7
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_CMP || op_code == OP_TEST)) |-> !res_wr);

    // R13
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !res_wr);

    // R6
    incdec_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC))
        |=> flags[CF_POS] == $past(flags[CF_POS]));

    // R5
    zero_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ADD || op_code == OP_SUB || op_code == OP_XOR))
        |=> flags[ZF_POS] == ($past(result) == '0));

    // R5
    parity_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ADD || op_code == OP_AND || op_code == OP_OR))
        |=> flags[PF_POS] == ~^$past(result[7:0]));

endmodule

bind alu_flags_top alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_code (op_code),
    .result  (result),
    .res_wr  (res_wr),
    .flags   (flags)
);

// File: tb/alu_flags_top_tb.sv
`timescale 1ns/1ps
module alu_flags_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [4:0]  op_code;
    logic [1:0]  op_size;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic        res_wr;
    logic [15:0] flags;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] mflags;
    bit          done = 0;

    always #10 clk = ~clk;

    alu_flags_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .res_wr(res_wr), .flags(flags)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R9";
            1, 2: return "R3";
            3, 4, 8: return "R4";
            5, 13: return "R7";
            6, 7: return "R6";
            9, 10, 11, 12: return "R8";
            14, 15, 16, 17: return "R10";
            18, 19, 20: return "R11";
            default: return "R1";
        endcase
    endfunction

    function automatic bit sgn(input longint unsigned v, input int w);
        return bit'(v >> (w - 1));
    endfunction

    // Behavioural model of one operation: result, write intent, new flags.
    function automatic void model(input int op, input int sz,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] fin,
                                  output logic [31:0] r, output logic wr,
                                  output logic [15:0] fo);
        int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        longint unsigned m  = (64'd1 << w) - 1;
        longint unsigned aa = a & m;
        longint unsigned bb = b & m;
        longint unsigned x = 0, y = 0, t = 0, rr = 0;
        bit c = fin[0];
        bit cf = 0, af = 0, of = 0, top, ci = 0, sub = 0;
        int kind = 0; // 0 none, 1 all, 2 all but carry, 3 carry+overflow
        top = sgn(aa, w);
        wr  = 1;
        case (op)
            0: rr = bb;
            1, 2, 3, 4, 5, 6, 7, 8: begin
                x = aa; y = bb; kind = 1;
                if (op == 2) ci = c;
                if (op == 4) ci = c;
                if (op >= 3 && op != 6) sub = 1;
                if (op == 6 || op == 7) begin y = 1; kind = 2; end
                if (op == 8) begin x = 0; y = aa; end
                if (op == 5) wr = 0;
                if (sub) begin
                    t  = x - y - ci;
                    cf = (x < y + ci);
                end else begin
                    t  = x + y + ci;
                    cf = bit'(t >> w);
                end
                rr = t & m;
                af = bit'((x ^ y ^ t) >> 4);
                if (sub) of = (sgn(x, w) != sgn(y, w)) && (sgn(rr, w) != sgn(x, w));
                else     of = (sgn(x, w) == sgn(y, w)) && (sgn(rr, w) != sgn(x, w));
            end
            9:  begin rr = aa & bb; kind = 1; end
            10: begin rr = aa | bb; kind = 1; end
            11: begin rr = aa ^ bb; kind = 1; end
            12: rr = (~aa) & m;
            13: begin rr = aa & bb; kind = 1; wr = 0; end
            14: begin rr = ((aa << 1) | top) & m; cf = top; of = sgn(rr, w) ^ cf; kind = 3; end
            15: begin rr = (aa >> 1) | ((aa & 1) << (w - 1)); cf = bit'(aa & 1);
                      of = sgn(rr, w) ^ sgn(rr, w - 1); kind = 3; end
            16: begin rr = ((aa << 1) | c) & m; cf = top; of = sgn(rr, w) ^ cf; kind = 3; end
            17: begin rr = (aa >> 1) | (longint'(c) << (w - 1)); cf = bit'(aa & 1);
                      of = sgn(rr, w) ^ sgn(rr, w - 1); kind = 3; end
            18: begin rr = (aa << 1) & m; cf = top; of = sgn(rr, w) ^ cf; kind = 1; end
            19: begin rr = aa >> 1; cf = bit'(aa & 1); of = top; kind = 1; end
            20: begin rr = (aa >> 1) | (longint'(top) << (w - 1)); cf = bit'(aa & 1); kind = 1; end
            default: begin rr = 0; wr = 0; end
        endcase
        r  = 32'(rr);
        fo = fin;
        if (kind == 1 || kind == 3) fo[0] = cf;
        if (kind == 1 || kind == 2 || kind == 3) fo[11] = of;
        if (kind == 1 || kind == 2) begin
            fo[4] = af;
            fo[6] = (rr == 0);
            fo[7] = sgn(rr, w);
            fo[2] = ~^r[7:0];
        end
    endfunction

    // Drive one operation, check result/write in the low phase, flags after the edge.
    task automatic do_op(input int op, input int sz, input logic [31:0] a,
                         input logic [31:0] b, output logic [31:0] got);
        logic [31:0] er; logic ew; logic [15:0] ef;
        @(negedge clk);
        op_valid = 1; op_code = 5'(op); op_size = 2'(sz); opnd_a = a; opnd_b = b;
        model(op, sz, a, b, mflags, er, ew, ef);
        #5;
        got = result;
        check(req_of(op), $sformatf("result op%0d sz%0d", op, sz), result, er);
        check("R13", $sformatf("res_wr op%0d", op), {31'd0, res_wr}, {31'd0, ew});
        @(posedge clk);
        #2;
        check(req_of(op), $sformatf("flags op%0d sz%0d", op, sz), {16'd0, flags}, {16'd0, ef});
        mflags = ef;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        op_valid = 0; op_code = 5'd1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
        #5;
        check("R13", "res_wr idle", {31'd0, res_wr}, 32'd0);
        @(posedge clk);
        #2;
        check("R1", "flags idle", {16'd0, flags}, {16'd0, mflags});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
        $display("  %0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] g, lo, hi;
        rst_n = 0; op_valid = 1; op_code = 5'd1; op_size = 2'd0;
        opnd_a = 32'hFF; opnd_b = 32'h1;
        repeat (3) @(posedge clk);
        #2;
        // R2 reset clears the whole status word
        check("R2", "reset flags", {16'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1; op_valid = 0;
        mflags = 16'h0;
        idle_cycle();

        // R3 byte add corner cases: carry/zero/half carry, then overflow
        do_op(1, 0, 32'h0000_00FF, 32'h0000_0001, g);
        check("R3", "byte wrap result", g, 32'h0);
        check("R2", "carry,parity,half,zero bits", {16'd0, flags}, 32'h0055);
        do_op(1, 0, 32'h0000_007F, 32'h0000_0001, g);
        check("R3", "signed overflow flags", {16'd0, flags}, 32'h0890);
        do_op(1, 1, 32'hABCD_8000, 32'h1111_8000, g);
        // R4 subtract, borrow and negate corners
        do_op(3, 2, 32'h0000_0000, 32'h0000_0001, g);
        do_op(3, 0, 32'h0000_0080, 32'h0000_0001, g);
        do_op(8, 0, 32'h0000_0000, 32'h0, g);
        do_op(8, 0, 32'h0000_0080, 32'h0, g);
        do_op(4, 1, 32'h0000_0005, 32'h0000_0005, g);
        // R6 carry survives inc/dec
        do_op(3, 2, 32'h0, 32'h1, g);
        do_op(6, 2, 32'h7FFF_FFFF, 32'h0, g);
        check("R6", "carry kept after inc", {31'd0, flags[0]}, 32'd1);
        do_op(7, 0, 32'h0000_0000, 32'h0, g);
        // R7 compare and test
        do_op(5, 2, 32'h10, 32'h20, g);
        do_op(13, 0, 32'hF0, 32'h0F, g);
        // R8 logic and NOT
        do_op(11, 2, 32'hFFFF_0000, 32'h00FF_FF00, g);
        do_op(12, 1, 32'h1234_00FF, 32'h0, g);
        // R10 / R11 each shift and rotate at each size
        for (int op = 14; op <= 20; op++)
            for (int sz = 0; sz <= 2; sz++) begin
                do_op(op, sz, 32'h8001_8081, 32'h0, g);
                do_op(op, sz, 32'h4000_4040, 32'h0, g);
            end
        // R1 undefined code
        do_op(25, 2, 32'h1, 32'h1, g);
        check("R1", "undefined code result", g, 32'h0);

        // R12 64-bit add with a move between the halves
        do_op(1, 2, 32'hFFFF_FFFF, 32'h0000_0001, lo);
        do_op(0, 2, 32'h0, 32'hDEAD_BEEF, g);
        do_op(2, 2, 32'h0000_0001, 32'h0000_0002, hi);
        check("R12", "64-bit add high word", hi, 32'h0000_0004);
        check("R12", "64-bit add low word", lo, 32'h0000_0000);
        // R12 64-bit logical right shift of 0x00000003_00000000
        do_op(19, 2, 32'h0000_0003, 32'h0, hi);
        do_op(0, 2, 32'h0, 32'h5555_5555, g);
        do_op(17, 2, 32'h0000_0000, 32'h0, lo);
        check("R12", "64-bit shift high word", hi, 32'h0000_0001);
        check("R12", "64-bit shift low word", lo, 32'h8000_0000);
        idle_cycle();

        // Mixed stream of all operations and sizes
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 7 == 0) a = 32'hFFFF_FFFF;
            if (i % 11 == 0) b = a;
            if (i % 13 == 0) a = 32'h8000_8080;
            do_op($urandom_range(0, 20), $urandom_range(0, 3) % 3, a, b, g);
            if (i % 50 == 0) idle_cycle();
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule